// File: doc/BRIEF.md
# Ping-Pong USB Transmit Endpoint Buffer

This block is the transmit store of a bulk-style USB function endpoint. It holds two packet halves of `PKT_BYTES` each, so the total capacity is always twice the largest packet. Software fills one half while the serial interface engine sends the other. Data enters through a 32-bit CPU port, which stores four bytes per write, or through a byte-wide DMA port, which stores the low byte of its bus. The contents of a half are undefined until they are written.

A commit pulse freezes the half being filled. Its byte count becomes the packet length, and filling moves to the other half. The drain side sees the oldest committed half as a packet with a length and a random-access byte output. A read pulse advances the byte output. A done pulse, given once the host has acknowledged the packet, frees the half for writing again. A clear pulse empties both halves.

Top module: `usb_tx_pingpong`

## Requirements
- R1: After reset `pkt_ready` is 0, `buf_avail` is 1 and `overflow` is 0.
- R2: An accepted CPU write stores `cpu_wr_data[7:0]` at the next byte position, followed by bits [15:8], [23:16] and [31:24], and adds 4 to the byte count of the half.
- R3: An accepted DMA write stores `dma_wr_data` as one byte and adds 1 to the count. When the CPU and DMA ports write in the same cycle, only the CPU word is stored and the DMA byte is dropped.
- R4: A commit to a free half raises `pkt_ready` on the next cycle. `pkt_len` then shows the number of bytes written to that half, and it stays constant until done or clear. Later writes go to the other half.
- R5: A half never holds more than `PKT_BYTES` bytes. Bytes that would go past the end are dropped, including the upper lanes of a CPU word that only partly fits, and `pkt_len` saturates at `PKT_BYTES`.
- R6: `rd_data` shows the byte of the ready packet at the read position, which starts at 0. Each `rd_en` advances the position by one until it reaches the last byte (`pkt_len`-1). After that, further `rd_en` pulses leave it on the last byte.
- R7: `tx_done` while `pkt_ready` is 1 frees the drained half and moves draining to the other half. `tx_done` while `pkt_ready` is 0 has no effect.
- R8: `buf_avail` is 1 exactly when the fill half is free. Writes made while it is 0 are discarded, and the half later fills from a count of 0.
- R9: A commit while `buf_avail` is 0 is ignored and sets `overflow`. `overflow` stays 1 until a clear.
- R10: `buf_clear` frees both halves, resets both counts and both positions, and clears `overflow`. It takes priority over any write, commit or done in the same cycle.
- R11: A write in the same cycle as an accepted commit is discarded. It is not counted in the committed packet or in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU word write strobe |
| cpu_wr_data | input | 32 | CPU write word, low byte stored first |
| dma_wr_en | input | 1 | DMA byte write strobe |
| dma_wr_data | input | 8 | DMA write byte |
| pkt_commit | input | 1 | Commit the fill half as a packet |
| buf_clear | input | 1 | Empty both halves |
| buf_avail | output | 1 | A free half is open for writing |
| overflow | output | 1 | Sticky rejected-commit flag |
| pkt_ready | output | 1 | A committed packet awaits sending |
| pkt_len | output | $clog2(PKT_BYTES+1) | Length of the ready packet |
| rd_data | output | 8 | Byte at the read position |
| rd_en | input | 1 | Advance the read position |
| tx_done | input | 1 | Host acknowledged the ready packet |

## Verification
All control state is registered, so the effect of any pulse on `pkt_ready`, `pkt_len`, `buf_avail` and `overflow` appears one cycle after the edge that samples the pulse. `rd_data` is combinational from the registered read position, so its new value is also due one cycle after an `rd_en`. The bench drives each pulse for exactly one cycle, starting on a falling edge. It compares results on the next falling edge, after the rising edge that registered the pulse. Expected bytes come from an arithmetic pattern of a seed and the byte index, and expected lengths come from saturating the written count at `PKT_BYTES`.

// File: rtl/usb_txpp_pkg.sv
package usb_txpp_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_DMA  = 2'd2
  } wr_src_e;

  localparam int WORD_LANES = 4;

  // Bytes of a request that still fit in a half holding 'used' bytes.
  function automatic int fit_bytes(input int used, input int want, input int cap);
    int room;
    room = cap - used;
    if (room < 0) room = 0;
    return (want < room) ? want : room;
  endfunction

  // Byte lane k of a 32-bit word, least-significant lane first.
  function automatic logic [7:0] word_lane(input logic [31:0] w, input int k);
    return w[8*k +: 8];
  endfunction

endpackage

// File: rtl/tx_write_merge.sv
module tx_write_merge
  import usb_txpp_pkg::*;
(
  input  logic        cpu_wr_en,
  input  logic [31:0] cpu_wr_data,
  input  logic        dma_wr_en,
  input  logic [7:0]  dma_wr_data,
  output logic        wr_req,
  output logic [2:0]  wr_want,
  output logic [31:0] wr_lanes,
  output wr_src_e     wr_src,
  output logic        dma_dropped
);

  always_comb begin
    wr_src   = SRC_NONE;
    wr_want  = 3'd0;
    wr_lanes = 32'd0;
    if (cpu_wr_en) begin
      wr_src   = SRC_CPU;
      wr_want  = 3'(WORD_LANES);
      wr_lanes = cpu_wr_data;
    end else if (dma_wr_en) begin
      wr_src   = SRC_DMA;
      wr_want  = 3'd1;
      wr_lanes = {24'd0, dma_wr_data};
    end
  end

  assign wr_req      = (wr_src != SRC_NONE);
  assign dma_dropped = cpu_wr_en && dma_wr_en;

endmodule

// File: rtl/tx_half_store.sv
module tx_half_store
  import usb_txpp_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  localparam int PTR_W = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_base,
  input  logic [2:0]       wr_count,
  input  logic [31:0]      wr_lanes,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rd_data
);

  logic [7:0]       mem [PKT_BYTES];
  logic [PTR_W-1:0] lane_addr [WORD_LANES];

  always_comb begin
    for (int k = 0; k < WORD_LANES; k++) begin
      lane_addr[k] = wr_base + PTR_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < WORD_LANES; k++) begin
        if (3'(k) < wr_count) mem[lane_addr[k]] <= word_lane(wr_lanes, k);
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tx_pingpong_ctrl.sv
module tx_pingpong_ctrl
  import usb_txpp_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  localparam int PTR_W = $clog2(PKT_BYTES),
  localparam int CNT_W = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [2:0]       wr_want,
  input  logic             commit,
  input  logic             done,
  input  logic             clear,
  output logic             fill_sel,
  output logic             drain_sel,
  output logic             buf_avail,
  output logic             pkt_ready,
  output logic [CNT_W-1:0] pkt_len,
  output logic             overflow,
  output logic [1:0]       wr_half_en,
  output logic [PTR_W-1:0] wr_base,
  output logic [2:0]       wr_count,
  output logic             commit_ok,
  output logic             commit_rej,
  output logic             wr_acc,
  output logic             done_ok
);

  logic             full_q [2];
  logic [CNT_W-1:0] cnt_q  [2];
  logic [CNT_W-1:0] len_q  [2];
  logic             fill_q, drain_q, ovf_q;
  logic             fill_free;
  logic [CNT_W-1:0] fill_cnt;

  assign fill_free  = !full_q[fill_q];
  assign fill_cnt   = cnt_q[fill_q];
  assign commit_ok  = commit && fill_free && !clear;
  assign commit_rej = commit && !fill_free && !clear;
  assign wr_acc     = wr_req && fill_free && !commit && !clear;
  assign done_ok    = done && full_q[drain_q] && !clear;
  assign wr_count   = wr_acc ? 3'(fit_bytes(int'(fill_cnt), int'(wr_want), PKT_BYTES)) : 3'd0;
  assign wr_base    = fill_cnt[PTR_W-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_wen
    assign wr_half_en[h] = (wr_count != 3'd0) && (fill_q == 1'(h));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin
        full_q[h] <= 1'b0;
        cnt_q[h]  <= '0;
        len_q[h]  <= '0;
      end
      fill_q  <= 1'b0;
      drain_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (clear) begin
      for (int h = 0; h < 2; h++) begin
        full_q[h] <= 1'b0;
        cnt_q[h]  <= '0;
        len_q[h]  <= '0;
      end
      fill_q  <= 1'b0;
      drain_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_count != 3'd0) cnt_q[fill_q] <= fill_cnt + CNT_W'(wr_count);
      if (commit_ok) begin
        full_q[fill_q] <= 1'b1;
        len_q[fill_q]  <= fill_cnt;
        fill_q         <= !fill_q;
      end
      if (done_ok) begin
        full_q[drain_q] <= 1'b0;
        cnt_q[drain_q]  <= '0;
        drain_q         <= !drain_q;
      end
      if (commit_rej) ovf_q <= 1'b1;
    end
  end

  assign fill_sel  = fill_q;
  assign drain_sel = drain_q;
  assign buf_avail = fill_free;
  assign pkt_ready = full_q[drain_q];
  assign pkt_len   = len_q[drain_q];
  assign overflow  = ovf_q;

endmodule

// File: rtl/tx_drain_ptr.sv
module tx_drain_ptr #(
  parameter int PKT_BYTES = 64,
  localparam int PTR_W = $clog2(PKT_BYTES),
  localparam int CNT_W = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             pkt_ready,
  input  logic [CNT_W-1:0] pkt_len,
  input  logic             restart,
  output logic [PTR_W-1:0] rd_addr,
  output logic             rd_step
);

  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] next_pos;

  assign next_pos = CNT_W'(ptr_q) + CNT_W'(1);
  assign rd_step  = rd_en && pkt_ready && (next_pos < pkt_len) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (restart) ptr_q <= '0;
    else if (rd_step) ptr_q <= ptr_q + PTR_W'(1);
  end

  assign rd_addr = ptr_q;

endmodule

// File: rtl/usb_tx_pingpong.sv
module usb_tx_pingpong
  import usb_txpp_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  localparam int PTR_W = $clog2(PKT_BYTES),
  localparam int CNT_W = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr_en,
  input  logic [31:0]      cpu_wr_data,
  input  logic             dma_wr_en,
  input  logic [7:0]       dma_wr_data,
  input  logic             pkt_commit,
  input  logic             buf_clear,
  output logic             buf_avail,
  output logic             overflow,
  output logic             pkt_ready,
  output logic [CNT_W-1:0] pkt_len,
  output logic [7:0]       rd_data,
  input  logic             rd_en,
  input  logic             tx_done
);

  logic             wr_req, dma_dropped;
  logic [2:0]       wr_want, wr_count;
  logic [31:0]      wr_lanes;
  wr_src_e          wr_src;
  logic             fill_sel, drain_sel;
  logic [1:0]       wr_half_en;
  logic [PTR_W-1:0] wr_base, rd_addr;
  logic             commit_ok, commit_rej, wr_acc, done_ok, rd_step;
  logic             ptr_restart;
  logic [7:0]       half_rd [2];

  tx_write_merge u_merge (
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .dma_wr_en   (dma_wr_en),
    .dma_wr_data (dma_wr_data),
    .wr_req      (wr_req),
    .wr_want     (wr_want),
    .wr_lanes    (wr_lanes),
    .wr_src      (wr_src),
    .dma_dropped (dma_dropped)
  );

  tx_pingpong_ctrl #(.PKT_BYTES(PKT_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .wr_want    (wr_want),
    .commit     (pkt_commit),
    .done       (tx_done),
    .clear      (buf_clear),
    .fill_sel   (fill_sel),
    .drain_sel  (drain_sel),
    .buf_avail  (buf_avail),
    .pkt_ready  (pkt_ready),
    .pkt_len    (pkt_len),
    .overflow   (overflow),
    .wr_half_en (wr_half_en),
    .wr_base    (wr_base),
    .wr_count   (wr_count),
    .commit_ok  (commit_ok),
    .commit_rej (commit_rej),
    .wr_acc     (wr_acc),
    .done_ok    (done_ok)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    tx_half_store #(.PKT_BYTES(PKT_BYTES)) u_store (
      .clk      (clk),
      .wr_en    (wr_half_en[h]),
      .wr_base  (wr_base),
      .wr_count (wr_count),
      .wr_lanes (wr_lanes),
      .rd_addr  (rd_addr),
      .rd_data  (half_rd[h])
    );
  end

  assign ptr_restart = done_ok || buf_clear;

  tx_drain_ptr #(.PKT_BYTES(PKT_BYTES)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .pkt_ready (pkt_ready),
    .pkt_len   (pkt_len),
    .restart   (ptr_restart),
    .rd_addr   (rd_addr),
    .rd_step   (rd_step)
  );

  assign rd_data = half_rd[drain_sel];

endmodule

// File: rtl/usb_tx_pingpong_chk.sv
module usb_tx_pingpong_chk #(
  parameter int PKT_BYTES = 64,
  localparam int CNT_W = $clog2(PKT_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             buf_clear,
  input logic             buf_avail,
  input logic             overflow,
  input logic             pkt_ready,
  input logic [CNT_W-1:0] pkt_len,
  input logic [7:0]       rd_data,
  input logic             rd_en,
  input logic             tx_done,
  input logic             commit_ok,
  input logic             commit_rej,
  input logic             done_ok
);

  AST_READY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> pkt_ready); // R4
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !tx_done && !buf_clear) |=> $stable(pkt_len)); // R4
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pkt_len) <= PKT_BYTES); // R5
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !rd_en && !tx_done && !buf_clear) |=> $stable(rd_data)); // R6
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> buf_avail); // R7
  AST_FULL_MEANS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_avail |-> pkt_ready); // R8
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    commit_rej |=> overflow); // R9
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !buf_clear) |=> overflow); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |=> (!pkt_ready && buf_avail && !overflow)); // R10

endmodule

bind usb_tx_pingpong usb_tx_pingpong_chk #(.PKT_BYTES(PKT_BYTES)) i_chk (.*);

// File: tb/test_usb_tx_pingpong.sv
`timescale 1ns/1ps
module test_usb_tx_pingpong;

  localparam int PKT = 64;
  localparam int CW  = $clog2(PKT + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_wr_en = 1'b0, dma_wr_en = 1'b0;
  logic [31:0]   cpu_wr_data = '0;
  logic [7:0]    dma_wr_data = '0;
  logic          pkt_commit = 1'b0, buf_clear = 1'b0, rd_en = 1'b0, tx_done = 1'b0;
  logic          buf_avail, overflow, pkt_ready;
  logic [CW-1:0] pkt_len;
  logic [7:0]    rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  usb_tx_pingpong #(.PKT_BYTES(PKT)) i_usb_tx_pingpong (.*);

  function automatic logic [7:0] pat(input int seed, input int idx);
    return 8'(seed * 37 + idx * 13 + 5);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cpu_wr_en = 0; dma_wr_en = 0; pkt_commit = 0; buf_clear = 0; rd_en = 0; tx_done = 0;
  endtask

  task automatic dma(input logic [7:0] b);
    dma_wr_en = 1; dma_wr_data = b; cyc();
  endtask

  task automatic cpu(input logic [31:0] w);
    cpu_wr_en = 1; cpu_wr_data = w; cyc();
  endtask

  function automatic logic [31:0] word_of(input int seed, input int base);
    return {pat(seed, base + 3), pat(seed, base + 2), pat(seed, base + 1), pat(seed, base)};
  endfunction

  task automatic commit();  pkt_commit = 1; cyc(); endtask
  task automatic done();    tx_done = 1;    cyc(); endtask
  task automatic clear();   buf_clear = 1;  cyc(); endtask

  // Drain the ready packet, checking length, every byte and the final hold.
  task automatic drain_check(input string req, input int seed, input int exp_len);
    chk({req, " ready"}, int'(pkt_ready), 1);
    chk({req, " len"}, int'(pkt_len), exp_len);
    for (int i = 0; i < exp_len; i++) begin
      chk({req, " R6 byte"}, int'(rd_data), int'(pat(seed, i)));
      rd_en = 1; cyc();
    end
    if (exp_len > 0) chk("R6 hold last", int'(rd_data), int'(pat(seed, exp_len - 1)));
    done();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R1
    chk("R1 ready", int'(pkt_ready), 0);
    chk("R1 avail", int'(buf_avail), 1);
    chk("R1 overflow", int'(overflow), 0);

    // R7: done with nothing ready is ignored
    done();
    chk("R7 idle done ready", int'(pkt_ready), 0);
    chk("R7 idle done avail", int'(buf_avail), 1);

    // R3, R4, R5: DMA sweep over lengths around the capacity
    for (int n = 0; n <= PKT + 2; n++) begin
      for (int i = 0; i < n; i++) dma(pat(n, i));
      commit();
      drain_check("R3 R4 R5 dma", n, (n < PKT) ? n : PKT);
    end

    // R2, R5: CPU word sweep, bytes stored low lane first
    for (int w = 0; w <= PKT / 4 + 1; w++) begin
      for (int j = 0; j < w; j++) cpu(word_of(100 + w, 4 * j));
      commit();
      drain_check("R2 R5 cpu", 100 + w, (4 * w < PKT) ? 4 * w : PKT);
    end

    // R5: partial fit of a CPU word on top of 62 DMA bytes
    for (int i = 0; i < PKT - 2; i++) dma(pat(7, i));
    cpu(word_of(7, PKT - 2));
    commit();
    drain_check("R5 partial word", 7, PKT);

    // R3: simultaneous CPU and DMA, the CPU word wins
    cpu_wr_en = 1; cpu_wr_data = word_of(9, 0); dma_wr_en = 1; dma_wr_data = 8'hEE; cyc();
    commit();
    drain_check("R3 cpu priority", 9, 4);

    // R11: write in the commit cycle is discarded
    dma(pat(11, 0)); dma(pat(11, 1));
    pkt_commit = 1; dma_wr_en = 1; dma_wr_data = 8'h55; cyc();
    commit();
    chk("R11 avail both full", int'(buf_avail), 0);
    drain_check("R11 committed", 11, 2);
    drain_check("R11 next empty", 0, 0);

    // R8, R9: both halves full, writes and commit rejected
    for (int i = 0; i < 3; i++) dma(pat(21, i));
    commit();
    chk("R8 avail one full", int'(buf_avail), 1);
    for (int i = 0; i < 5; i++) dma(pat(22, i));
    commit();
    chk("R8 avail none", int'(buf_avail), 0);
    dma(8'hAA); cpu(32'hDEADBEEF);
    commit();
    chk("R9 overflow set", int'(overflow), 1);
    drain_check("R8 first kept", 21, 3);
    chk("R8 avail after done", int'(buf_avail), 1);
    commit();
    drain_check("R8 second kept", 22, 5);
    drain_check("R8 ignored writes", 0, 0);
    chk("R9 overflow sticky", int'(overflow), 1);

    // R10: clear with a simultaneous commit
    dma(pat(30, 0));
    commit();
    dma(pat(31, 0));
    buf_clear = 1; pkt_commit = 1; cyc();
    chk("R10 ready", int'(pkt_ready), 0);
    chk("R10 avail", int'(buf_avail), 1);
    chk("R10 overflow", int'(overflow), 0);
    commit();
    drain_check("R10 count reset", 0, 0);
    chk("R10 empty after", int'(pkt_ready), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule